// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog for a small 8-bit controller, reached through a byte-wide register bus made of an address, write data, a write strobe and combinational read data. Software sets a divider select and an enable bit in a control register. While the watchdog runs, a counter advances once per clock. If software does not feed it a refresh key before the selected period ends, the block raises a one-cycle reset request.

Stray code must not be able to reconfigure the watchdog. So the control register takes a write only right after a three-byte unlock sequence has gone to a separate key register. Feeding uses its own register, and only one specific byte value counts as a refresh. A hardware option input can hold the watchdog off whatever software has programmed. The prescaler exponent base is a parameter, so the period for each select value suits the system clock.

Register offsets: 0 = control, 1 = unlock key, 2 = refresh key, 3 = reads zero.

Top module: `kwdt_top`

## Requirements
- R1: After reset the control register reads 0x00, the refresh-key register reads 0x00, and `rst_req_o` is low.
- R2: A write to the control register takes effect only when the three writes to the unlock key register just before it were 0x55, then 0xAA, then 0x5A. Any other control write leaves the register unchanged.
- R3: A wrong byte in the unlock sequence sends it back to the start. A 0x55 written at any point counts as a new first byte.
- R4: One unlock allows exactly one control write. Any write to an address other than the unlock key register, or a second control write, cancels the unlock.
- R5: Control register layout: bits [3:0] hold the divider select, bit 5 holds the software enable, and bit 7 is a read-only sticky timeout flag. Bits 4 and 6 read 0.
- R6: With the watchdog running and never fed, the first reset request comes 2^(select+BASE_EXP) clock cycles after the clock edge that enabled it. With the default BASE_EXP of 10, select 1000b gives 2^18 cycles, which is 262.144 ms at a 1 MHz clock. Writing 0x28 to the control register enables it with select 1000b.
- R7: The reset request lasts exactly one cycle. The counter then restarts from zero, so the next request follows one full period later.
- R8: Writing 0x55 to the refresh-key register clears the counter to zero, so the next request comes one full period after that write. The refresh-key register reads back the last byte written to it.
- R9: Writing any other value to the refresh-key register leaves the counter unaffected.
- R10: While `force_off_i` is 1 the watchdog makes no request and the counter stays at zero. The enable bit can still be written and read back.
- R11: With the software enable at 0 the counter stays at zero and no request is made.
- R12: A timeout sets the sticky flag, and the flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| force_off_i | input | 1 | Hardware option: 1 holds the watchdog off |
| bus_addr | input | ADDR_W (2) | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| rst_req_o | output | 1 | One-cycle reset request on timeout |

## Verification
The checker looks at every cycle. It confirms that the control fields change only on the cycle after an accepted unlocked write, that an accepted write always closes the unlock window, and that a refresh always leaves the counter at zero. It also confirms that a request never lasts two cycles, never appears while the option input is holding the watchdog off, and always comes with the sticky flag. The exact period for each select value, the ignored wrong refresh bytes, and the restart rules of the unlock sequence under mixed byte streams depend on counts and orderings, so only the bench scenarios show them. The bench measures these at the ports against its own model.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 4;

  localparam logic [DATA_W-1:0] UNLOCK_B1   = 8'h55;
  localparam logic [DATA_W-1:0] UNLOCK_B2   = 8'hAA;
  localparam logic [DATA_W-1:0] UNLOCK_B3   = 8'h5A;
  localparam logic [DATA_W-1:0] FEED_MAGIC  = 8'h55;

  // control register bit positions
  localparam int CTL_EN_BIT   = 5;
  localparam int CTL_FLAG_BIT = 7;

  typedef enum logic [1:0] {
    UL_IDLE = 2'd0,
    UL_GOT1 = 2'd1,
    UL_GOT2 = 2'd2,
    UL_OPEN = 2'd3
  } ul_state_e;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } wdt_cfg_t;

  // exponent of the period in clock cycles
  function automatic int unsigned period_exp(input logic [SEL_W-1:0] sel,
                                             input int unsigned base);
    return int'(sel) + base;
  endfunction

  // next state of the unlock sequencer for one bus write
  function automatic ul_state_e ul_next(input ul_state_e cur,
                                        input logic is_key,
                                        input logic [DATA_W-1:0] d);
    ul_state_e n;
    n = UL_IDLE;
    if (is_key) begin
      if (d == UNLOCK_B1)                         n = UL_GOT1;
      else if (cur == UL_GOT1 && d == UNLOCK_B2)  n = UL_GOT2;
      else if (cur == UL_GOT2 && d == UNLOCK_B3)  n = UL_OPEN;
      else                                        n = UL_IDLE;
    end
    return n;
  endfunction
endpackage

// File: rtl/kwdt_unlock.sv
module kwdt_unlock
  import kwdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              wr_is_key_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              open_o
);
  ul_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= UL_IDLE;
    else if (wr_i) state_q <= ul_next(state_q, wr_is_key_i, wdata_i);
  end

  assign open_o = (state_q == UL_OPEN);
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
#(
  parameter int unsigned BASE_EXP = 10,
  localparam int unsigned CNT_W   = BASE_EXP + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             refresh_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             terminal_o,
  output logic             cnt_zero_o,
  output logic             req_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;

  // last count value before terminal: 2^exp - 1
  function automatic logic [CNT_W-1:0] last_of(input logic [SEL_W-1:0] s);
    int unsigned e;
    e = period_exp(s, BASE_EXP);
    return {CNT_W{1'b1}} >> (CNT_W - e);
  endfunction

  assign last_cnt   = last_of(sel_i);
  assign terminal_o = active_i && !refresh_i && (cnt_q >= last_cnt);
  assign cnt_zero_o = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_o <= 1'b0;
    end else begin
      req_o <= terminal_o;
      if (!active_i || refresh_i || terminal_o) cnt_q <= '0;
      else                                      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned BASE_EXP  = 10,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned KEY_ADDR  = 1,
  parameter int unsigned FEED_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              force_off_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  output logic [7:0]        bus_rdata,
  output logic              rst_req_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(KEY_ADDR);
  localparam logic [ADDR_W-1:0] A_FEED = ADDR_W'(FEED_ADDR);

  wdt_cfg_t    cfg_q;
  logic [7:0]  feed_q;
  logic        timeout_flag;

  // named internal events
  logic        wr_key, wr_ctrl, wr_feed;
  logic        unlocked;
  logic        ctrl_accept;
  logic        refresh_hit;
  logic        wdt_active;
  logic        terminal;
  logic        cnt_zero;

  assign wr_key      = bus_we && (bus_addr == A_KEY);
  assign wr_ctrl     = bus_we && (bus_addr == A_CTRL);
  assign wr_feed     = bus_we && (bus_addr == A_FEED);
  assign ctrl_accept = wr_ctrl && unlocked;
  assign refresh_hit = wr_feed && (bus_wdata == FEED_MAGIC);
  assign wdt_active  = cfg_q.en && !force_off_i;

  kwdt_unlock u_unlock (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_i        (bus_we),
    .wr_is_key_i (wr_key),
    .wdata_i     (bus_wdata),
    .open_o      (unlocked)
  );

  kwdt_counter #(.BASE_EXP(BASE_EXP)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_i   (wdt_active),
    .refresh_i  (refresh_hit),
    .sel_i      (cfg_q.sel),
    .terminal_o (terminal),
    .cnt_zero_o (cnt_zero),
    .req_o      (rst_req_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q        <= '0;
      feed_q       <= '0;
      timeout_flag <= 1'b0;
    end else begin
      if (ctrl_accept) begin
        cfg_q.en  <= bus_wdata[CTL_EN_BIT];
        cfg_q.sel <= bus_wdata[SEL_W-1:0];
      end
      if (wr_feed)  feed_q       <= bus_wdata;
      if (terminal) timeout_flag <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) begin
      bus_rdata[SEL_W-1:0]    = cfg_q.sel;
      bus_rdata[CTL_EN_BIT]   = cfg_q.en;
      bus_rdata[CTL_FLAG_BIT] = timeout_flag;
    end else if (bus_addr == A_FEED) begin
      bus_rdata = feed_q;
    end
  end
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       force_off_i,
  input logic       rst_req_o,
  input logic       unlocked,
  input logic       ctrl_accept,
  input logic       refresh_hit,
  input logic       cnt_zero,
  input logic       timeout_flag,
  input logic [4:0] cfg_bits
);
  p_cfg_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_bits) |-> $past(ctrl_accept));

  p_single_use_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_accept |=> !unlocked);

  p_pulse_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  p_refresh_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_hit |=> cnt_zero);

  p_forced_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> $past(!force_off_i));

  p_forced_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(force_off_i) |-> cnt_zero);

  p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |=> timeout_flag);

  p_flag_with_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> timeout_flag);
endmodule

bind kwdt_top kwdt_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .force_off_i  (force_off_i),
  .rst_req_o    (rst_req_o),
  .unlocked     (unlocked),
  .ctrl_accept  (ctrl_accept),
  .refresh_hit  (refresh_hit),
  .cnt_zero     (cnt_zero),
  .timeout_flag (timeout_flag),
  .cfg_bits     (cfg_q)
);

// File: tb/kwdt_top_tb.sv
module kwdt_top_tb_top;
  localparam int BASE = 2;
  localparam logic [1:0] A_CTRL = 2'd0, A_KEY = 2'd1, A_FEED = 2'd2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       force_off_i = 1'b1;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic       rst_req_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  kwdt_top #(.BASE_EXP(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .force_off_i(force_off_i),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .rst_req_o(rst_req_o)
  );

  function automatic int period(input int sel);
    return 1 << (sel + BASE);
  endfunction

  // bench model of the unlock sequence: 0 idle, 1..2 partial, 3 open
  function automatic int ul_model(input int st, input logic [1:0] a,
                                  input logic [7:0] d);
    if (a != A_KEY) return 0;
    if (d == 8'h55) return 1;
    if (st == 1 && d == 8'hAA) return 2;
    if (st == 2 && d == 8'h5A) return 3;
    return 0;
  endfunction

  function automatic logic [7:0] ctrl_view(input logic [7:0] w, input bit flag);
    return {flag, 1'b0, w[5], 1'b0, w[3:0]};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bread(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    bwrite(A_KEY, 8'h55); bwrite(A_KEY, 8'hAA); bwrite(A_KEY, 8'h5A);
  endtask

  // after a write or pulse at reference point: no request for p-1, then one
  task automatic expect_pulse_after(input string req, input int p);
    waitn(p - 1);
    chk(req, {7'd0, rst_req_o}, 8'd0);
    waitn(1);
    chk(req, {7'd0, rst_req_o}, 8'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] exp_ctrl;
    int st;
    int dummy;
    dummy = $urandom(32'h5EED_0042);
    waitn(3);
    rst_n = 1'b1;
    waitn(1);

    // R1 reset state
    bread(A_CTRL, rd); chk("R1 ctrl", rd, 8'h00);
    bread(A_FEED, rd); chk("R1 feed", rd, 8'h00);
    chk("R1 req", {7'd0, rst_req_o}, 8'd0);

    // R2 write without unlock ignored
    bwrite(A_CTRL, 8'h23);
    bread(A_CTRL, rd); chk("R2 locked write", rd, 8'h00);
    // R2 / R6 accepted write, stated example value
    unlock(); bwrite(A_CTRL, 8'h28);
    bread(A_CTRL, rd); chk("R2 unlocked write", rd, 8'h28);
    // R5 bits 4 and 6 read zero, bit 7 not writable
    unlock(); bwrite(A_CTRL, 8'hFF);
    bread(A_CTRL, rd); chk("R5 layout", rd, 8'h2F);
    // R4 second write after one unlock ignored
    unlock(); bwrite(A_CTRL, 8'h01); bwrite(A_CTRL, 8'h07);
    bread(A_CTRL, rd); chk("R4 single use", rd, 8'h01);
    // R4 write elsewhere cancels
    unlock(); bwrite(A_FEED, 8'h12); bwrite(A_CTRL, 8'h09);
    bread(A_CTRL, rd); chk("R4 cancel", rd, 8'h01);
    // R3 wrong byte restarts
    bwrite(A_KEY, 8'h55); bwrite(A_KEY, 8'h00); bwrite(A_KEY, 8'hAA);
    bwrite(A_KEY, 8'h5A); bwrite(A_CTRL, 8'h03);
    bread(A_CTRL, rd); chk("R3 wrong byte", rd, 8'h01);
    // R3 repeated 0x55 restarts as first byte
    bwrite(A_KEY, 8'h55); bwrite(A_KEY, 8'h55); bwrite(A_KEY, 8'hAA);
    bwrite(A_KEY, 8'h5A); bwrite(A_CTRL, 8'h02);
    bread(A_CTRL, rd); chk("R3 restart on 55", rd, 8'h02);
    // R3 out of order
    bwrite(A_KEY, 8'hAA); bwrite(A_KEY, 8'h55); bwrite(A_KEY, 8'h5A);
    bwrite(A_CTRL, 8'h04);
    bread(A_CTRL, rd); chk("R3 order", rd, 8'h02);

    // constrained random unlock/control traffic, watchdog forced off (R2 R3 R4 R10)
    st = 0;
    exp_ctrl = 8'h02;
    for (int i = 0; i < 400; i++) begin
      int r;
      logic [1:0] a;
      logic [7:0] d;
      r = $urandom_range(0, 9);
      a = (r < 6) ? A_KEY : (r < 9) ? A_CTRL : A_FEED;
      case ($urandom_range(0, 4))
        0: d = 8'h55;
        1: d = 8'hAA;
        2: d = 8'h5A;
        default: d = 8'($urandom);
      endcase
      if (a == A_CTRL && st == 3) exp_ctrl = ctrl_view(d, 1'b0);
      st = ul_model(st, a, d);
      bwrite(a, d);
      bread(A_CTRL, rd); chk("R2 random ctrl", rd, exp_ctrl);
      chk("R10 random quiet", {7'd0, rst_req_o}, 8'd0);
      if (a == A_FEED) begin
        bread(A_FEED, rd); chk("R8 feed readback", rd, d);
      end
    end

    // R11 software disabled: no request
    unlock(); bwrite(A_CTRL, 8'h01);
    force_off_i = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); chk("R11 disabled", {7'd0, rst_req_o}, 8'd0);
    end

    // R6 enable sel 1
    unlock(); bwrite(A_CTRL, 8'h21);
    expect_pulse_after("R6 first timeout", period(1));
    // R7 one cycle then full period again
    waitn(1); chk("R7 one cycle", {7'd0, rst_req_o}, 8'd0);
    waitn(period(1) - 2); chk("R7 quiet", {7'd0, rst_req_o}, 8'd0);
    waitn(1); chk("R7 second timeout", {7'd0, rst_req_o}, 8'd1);
    // R12 flag
    bread(A_CTRL, rd); chk("R12 flag set", rd, 8'hA1);
    // R8 refresh restarts the period
    waitn(3); bwrite(A_FEED, 8'h55);
    expect_pulse_after("R8 refresh", period(1));
    // R9 wrong key: pulse at the original time
    waitn(2); bwrite(A_FEED, 8'hAA);
    waitn(period(1) - 4); chk("R9 quiet", {7'd0, rst_req_o}, 8'd0);
    waitn(1); chk("R9 unaffected", {7'd0, rst_req_o}, 8'd1);
    bread(A_FEED, rd); chk("R8 readback", rd, 8'hAA);

    // R10 force off with sel 3
    unlock(); bwrite(A_CTRL, 8'h23);
    force_off_i = 1'b1;
    for (int i = 0; i < 3 * period(3); i++) begin
      @(negedge clk); chk("R10 forced", {7'd0, rst_req_o}, 8'd0);
    end
    unlock(); bwrite(A_CTRL, 8'h03);
    bread(A_CTRL, rd); chk("R10 enable writable", rd, 8'h83);
    unlock(); bwrite(A_CTRL, 8'h23);
    bread(A_CTRL, rd); chk("R10 enable readable", rd, 8'hA3);
    waitn(5);
    force_off_i = 1'b0;
    expect_pulse_after("R10 release full period", period(3));

    // R6 stated select 1000b
    force_off_i = 1'b1;
    unlock(); bwrite(A_CTRL, 8'h28);
    force_off_i = 1'b0;
    expect_pulse_after("R6 sel 1000b", period(8));
    bread(A_CTRL, rd); chk("R12 flag stays", rd, 8'hA8);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule